// File: doc/BRIEF.md
# Line Interface Bring-Up Sequencer

This block is the host-side controller that takes an isolated telephone line interface from power-on to a working state. It writes the sample-rate setting to the clock generator while the line side is still powered down. It then releases the power-down control and waits for the link-valid status. Next it raises off-hook and checks that link-valid is still present. It waits out the calibration interval and finally applies the requested test mode. All waits are counted in ticks of an external timebase; with a 1 µs tick the default parameters give a 402750-tick calibration wait, 10000-tick link deadlines and a 1000-tick power-down pulse.

When link-valid does not appear in time, either after power-down is released or after off-hook is raised, the attempt fails. The sequencer then holds power-down high for at least the minimum reset-pulse length and tries again, up to a parameterised number of retries. After the last failed attempt it parks in a fault state with power-down high. Dropping the start request at any time outside the fault state returns the interface to power-down with off-hook released.

Top module: `line_bringup_seq`

## Requirements
- R1: While reset is high and after reset with start low, power_down is 1 and clk_cfg_wr, off_hook, ready, fault and mode_onehot are all 0.
- R2: A start request causes exactly one single-cycle clk_cfg_wr pulse, with clk_rate equal to rate_sel, while power_down is still 1. power_down clears only after that pulse, and off_hook is never 1 while power_down is 1.
- R3: If link_valid is not high within LINK_TICKS ticks after power_down clears, the attempt fails.
- R4: If link_valid is not high within LINK_TICKS ticks after off_hook rises, the attempt fails.
- R5: After the off-hook check passes, off_hook stays 1 and the test mode is not applied (ready stays 0) until at least CAL_TICKS ticks have elapsed; the whole off-hook-to-ready span is at most CAL_TICKS+4 ticks.
- R6: On a failed attempt, off_hook drops and power_down is held 1 for at least PD_TICKS ticks, after which power_down clears for a new attempt.
- R7: At most MAX_RETRY power-down retry pulses occur. The next failure sets fault to 1 with power_down 1, off_hook 0, ready 0 and mode_onehot 0.
- R8: fault stays 1 while start is low. Only a rising edge of start clears it and begins a new sequence.
- R9: mode_onehot holds at most one set bit. It is the decode of test_mode applied after calibration: code 0 selects no test mode (all zeros), and code k>0 sets bit k-1.
- R10: ready is 1 only while the sequence is complete with off_hook 1. It follows link_valid with one cycle of delay, and off_hook stays 1 while link_valid is low in that state.
- R11: Outside the fault state, one cycle after start is seen low, power_down is 1 and off_hook, ready and mode_onehot are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Bring-up request, held high while the interface is wanted |
| rate_sel | input | RATE_W | Sample-rate setting to program |
| test_mode | input | MODE_W | Requested mode code, 0 = normal operation |
| link_valid | input | 1 | Status that the isolation link is communicating |
| tick | input | 1 | Timebase strobe, one cycle per time unit |
| clk_cfg_wr | output | 1 | Single-cycle write strobe to the clock generator |
| clk_rate | output | RATE_W | Rate value presented with clk_cfg_wr |
| power_down | output | 1 | Line-side power-down control |
| off_hook | output | 1 | Off-hook control |
| mode_onehot | output | 2**MODE_W-1 | One-hot test-mode enables |
| ready | output | 1 | Interface operational in the selected mode |
| fault | output | 1 | Retries exhausted |

## Verification
The bench builds the sequencer with CAL_TICKS=40, LINK_TICKS=12, PD_TICKS=6 and MAX_RETRY=2, which keeps each bring-up to a few hundred cycles. At these values every path is reached within one run: success on the first attempt, recovery after one or two failures in either deadline, and exhaustion into the fault state. A link model in the bench fails chosen attempts before or after off-hook, and a tick divider of 1 or 2 checks that the waits count timebase ticks rather than clock cycles.

// File: rtl/lbs_pkg.sv
`timescale 1ns/1ps
package lbs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_CLKCFG   = 4'd1,
    ST_LINKWAIT = 4'd2,
    ST_OFFHOOK  = 4'd3,
    ST_CAL      = 4'd4,
    ST_APPLY    = 4'd5,
    ST_RUN      = 4'd6,
    ST_PDPULSE  = 4'd7,
    ST_FAULT    = 4'd8
  } bring_st_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lbs_tick_timer.sv
`timescale 1ns/1ps
module lbs_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R5
  timer_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && (cnt_q == '0)) |=> (cnt_q == '0));

endmodule

// File: rtl/lbs_retry_ctr.sv
`timescale 1ns/1ps
module lbs_retry_ctr #(
  parameter int MAX_RETRY = 3,
  parameter int W         = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic full
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q != W'(MAX_RETRY))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign full = (cnt_q == W'(MAX_RETRY));

  // R7
  retry_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= W'(MAX_RETRY));

endmodule

// File: rtl/lbs_mode_dec.sv
`timescale 1ns/1ps
module lbs_mode_dec #(
  parameter int MODE_W = 2,
  parameter int NMODE  = 3
) (
  input  logic [MODE_W-1:0] code,
  output logic [NMODE-1:0]  onehot
);

  for (genvar i = 0; i < NMODE; i++) begin : g_bit
    assign onehot[i] = (code == MODE_W'(i + 1));
  end

endmodule

// File: rtl/line_bringup_seq.sv
`timescale 1ns/1ps
module line_bringup_seq
  import lbs_pkg::*;
#(
  parameter int CAL_TICKS  = 402750,
  parameter int LINK_TICKS = 10000,
  parameter int PD_TICKS   = 1000,
  parameter int MAX_RETRY  = 3,
  parameter int RATE_W     = 4,
  parameter int MODE_W     = 2,
  localparam int NMODE     = (1 << MODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [MODE_W-1:0] test_mode,
  input  logic              link_valid,
  input  logic              tick,
  output logic              clk_cfg_wr,
  output logic [RATE_W-1:0] clk_rate,
  output logic              power_down,
  output logic              off_hook,
  output logic [NMODE-1:0]  mode_onehot,
  output logic              ready,
  output logic              fault
);

  localparam int MAXT = max3(CAL_TICKS, LINK_TICKS, PD_TICKS);
  localparam int TW   = $clog2(MAXT + 1);
  localparam int RW   = $clog2(MAX_RETRY + 2);

  bring_st_e st_q, st_n;
  logic      start_q, start_rise;
  logic      fail_now;
  logic      tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic      rty_clr, rty_inc, rty_full;
  logic [NMODE-1:0] mode_dec;

  assign start_rise = start && !start_q;

  // ---------------- next-state logic ----------------
  always_comb begin
    st_n     = st_q;
    fail_now = 1'b0;
    case (st_q)
      ST_IDLE:     if (start) st_n = ST_CLKCFG;
      ST_CLKCFG:   st_n = ST_LINKWAIT;
      ST_LINKWAIT: begin
        if (link_valid)    st_n = ST_OFFHOOK;
        else if (tmr_done) fail_now = 1'b1;
      end
      ST_OFFHOOK: begin
        if (link_valid)    st_n = ST_CAL;
        else if (tmr_done) fail_now = 1'b1;
      end
      ST_CAL:      if (tmr_done) st_n = ST_APPLY;
      ST_APPLY:    st_n = ST_RUN;
      ST_RUN:      st_n = ST_RUN;
      ST_PDPULSE:  if (tmr_done) st_n = ST_LINKWAIT;
      ST_FAULT:    if (start_rise) st_n = ST_CLKCFG;
      default:     st_n = ST_IDLE;
    endcase
    if (fail_now) st_n = rty_full ? ST_FAULT : ST_PDPULSE;
    if (!start && (st_q != ST_FAULT)) st_n = ST_IDLE;
  end

  // ---------------- timer load selection ----------------
  always_comb begin
    tmr_load = (st_n != st_q);
    case (st_n)
      ST_LINKWAIT, ST_OFFHOOK: tmr_val = TW'(LINK_TICKS);
      ST_CAL:                  tmr_val = TW'(CAL_TICKS);
      ST_PDPULSE:              tmr_val = TW'(PD_TICKS);
      default:                 tmr_val = '0;
    endcase
  end

  assign rty_clr = (st_n == ST_CLKCFG);
  assign rty_inc = (st_n == ST_PDPULSE) && (st_q != ST_PDPULSE);

  lbs_tick_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (tick),
    .done     (tmr_done)
  );

  lbs_retry_ctr #(.MAX_RETRY(MAX_RETRY), .W(RW)) u_retry (
    .clk  (clk),
    .rst  (rst),
    .clr  (rty_clr),
    .inc  (rty_inc),
    .full (rty_full)
  );

  lbs_mode_dec #(.MODE_W(MODE_W), .NMODE(NMODE)) u_mode_dec (
    .code   (test_mode),
    .onehot (mode_dec)
  );

  // ---------------- state and registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      start_q     <= 1'b0;
      clk_cfg_wr  <= 1'b0;
      clk_rate    <= '0;
      power_down  <= 1'b1;
      off_hook    <= 1'b0;
      mode_onehot <= '0;
      ready       <= 1'b0;
      fault       <= 1'b0;
    end else begin
      st_q       <= st_n;
      start_q    <= start;
      clk_cfg_wr <= (st_n == ST_CLKCFG);
      if (st_n == ST_CLKCFG) clk_rate <= rate_sel;
      power_down <= (st_n == ST_IDLE) || (st_n == ST_CLKCFG) ||
                    (st_n == ST_PDPULSE) || (st_n == ST_FAULT);
      off_hook   <= (st_n == ST_OFFHOOK) || (st_n == ST_CAL) ||
                    (st_n == ST_APPLY) || (st_n == ST_RUN);
      if (st_n == ST_APPLY)    mode_onehot <= mode_dec;
      else if (st_n != ST_RUN) mode_onehot <= '0;
      ready      <= (st_n == ST_RUN) && link_valid;
      fault      <= (st_n == ST_FAULT);
    end
  end

  // ---------------- checks ----------------
  logic [TW-1:0] pd_seen_q;
  always_ff @(posedge clk) begin
    if (rst || (st_q != ST_PDPULSE)) pd_seen_q <= '0;
    else if (tick && (pd_seen_q != '1)) pd_seen_q <= pd_seen_q + 1'b1;
  end

  // R2
  cfg_while_down_chk: assert property (@(posedge clk) disable iff (rst)
    clk_cfg_wr |-> (power_down && !off_hook));

  // R2
  cfg_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    clk_cfg_wr |=> !clk_cfg_wr);

  // R2
  hook_needs_power_chk: assert property (@(posedge clk) disable iff (rst)
    off_hook |-> !power_down);

  // R6
  pd_pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PDPULSE && st_n == ST_LINKWAIT) |-> (pd_seen_q >= TW'(PD_TICKS - 1)));

  // R7
  fault_safe_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> (power_down && !off_hook && !ready && (mode_onehot == '0)));

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fault && !start) |=> fault);

  // R9
  mode_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mode_onehot));

  // R10
  ready_needs_hook_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> off_hook);

  // R11
  start_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> (power_down && !off_hook && !ready));

endmodule

// File: tb/line_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module line_bringup_seq_tb_top;

  localparam int CAL   = 40;
  localparam int LINK  = 12;
  localparam int PD    = 6;
  localparam int RETRY = 2;
  localparam int RW    = 4;
  localparam int MW    = 2;
  localparam int NM    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [RW-1:0] rate_sel = '0;
  logic [MW-1:0] test_mode = '0;
  logic link_valid = 1'b0;
  logic tick = 1'b0;
  logic clk_cfg_wr, power_down, off_hook, ready, fault;
  logic [RW-1:0] clk_rate;
  logic [NM-1:0] mode_onehot;

  always #2.5 clk = ~clk;

  line_bringup_seq #(
    .CAL_TICKS(CAL), .LINK_TICKS(LINK), .PD_TICKS(PD), .MAX_RETRY(RETRY),
    .RATE_W(RW), .MODE_W(MW)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .rate_sel(rate_sel),
    .test_mode(test_mode), .link_valid(link_valid), .tick(tick),
    .clk_cfg_wr(clk_cfg_wr), .clk_rate(clk_rate), .power_down(power_down),
    .off_hook(off_hook), .mode_onehot(mode_onehot), .ready(ready), .fault(fault)
  );

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // columns: rate, mode, fail_n, kind(1=link never up, 2=drops at off-hook), delay, tdiv, exp_fault
  localparam int NV = 7;
  localparam int TBL [NV][7] = '{
    '{3,  0, 0, 0, 2,  1, 0},
    '{5,  1, 1, 1, 3,  1, 0},
    '{9,  2, 1, 2, 1,  2, 0},
    '{12, 3, 2, 1, 0,  1, 0},
    '{7,  2, 3, 1, 0,  1, 1},
    '{1,  3, 3, 2, 2,  2, 1},
    '{2,  1, 0, 0, 11, 1, 0}
  };

  // environment: link model, tick source and monitor
  int cur_fail_n = 0, cur_kind = 0, cur_delay = 1, tdiv = 1;
  bit force_low = 0, mon_en = 0, mon_clr = 0;
  int lcnt = 0, tcnt = 0, att = 0;
  int fails = 0, min_pd = 0, pd_ticks = 0, att_ticks = 0, cal_ticks = 0;
  int cfg_pulses = 0, order_err = 0, dl_err = 0;
  bit prev_pd = 1, prev_oh = 0, prev_rdy = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (mon_clr) begin
        att = 0; fails = 0; min_pd = 1000000; pd_ticks = 0; att_ticks = 0;
        cal_ticks = 0; cfg_pulses = 0; order_err = 0; dl_err = 0; mon_clr = 0;
      end
      if (mon_en) begin
        if (prev_pd && tick) pd_ticks++;
        if (!prev_pd && tick) att_ticks++;
        if (prev_oh && !prev_rdy && tick) cal_ticks++;
        if (power_down && !prev_pd) begin
          fails++;
          if (att_ticks < LINK) dl_err++;
          pd_ticks = 0;
        end
        if (!power_down && prev_pd) begin
          att++;
          att_ticks = 0;
          if (fails > 0 && pd_ticks < min_pd) min_pd = pd_ticks;
        end
        if (off_hook && !prev_oh) cal_ticks = 0;
        if (off_hook && power_down) order_err++;
        if (clk_cfg_wr) begin
          cfg_pulses++;
          if (!power_down) order_err++;
        end
      end
      prev_pd = power_down; prev_oh = off_hook; prev_rdy = ready;
      if (power_down) lcnt = 0; else lcnt++;
      if (force_low || power_down || lcnt < cur_delay) link_valid = 1'b0;
      else if (att <= cur_fail_n && cur_kind == 1) link_valid = 1'b0;
      else if (att <= cur_fail_n && cur_kind == 2) link_valid = !off_hook;
      else link_valid = 1'b1;
      tick = ((tcnt % tdiv) == 0);
      tcnt++;
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (ready || fault) begin ok = 1; break; end
    end
  endtask

  task automatic run_entry(input int i);
    int rate, mode, fn, ef, exp_fails, exp_oh;
    bit ok;
    rate = TBL[i][0]; mode = TBL[i][1]; fn = TBL[i][2]; ef = TBL[i][6];
    @(negedge clk);
    cur_fail_n = fn; cur_kind = TBL[i][3]; cur_delay = TBL[i][4]; tdiv = TBL[i][5];
    rate_sel = RW'(rate); test_mode = MW'(mode);
    mon_clr = 1; mon_en = 1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    chk(fault == 1'b0, "R8 fault cleared by start rise", fault, 0);
    wait_done(ok);
    chk(ok, "R7 sequence completes", ok, 1);
    repeat (2) @(negedge clk);
    exp_fails = ef ? RETRY + 1 : fn;
    exp_oh = (mode == 0) ? 0 : (1 << (mode - 1));
    chk(fault == ef[0], "R7 fault outcome", fault, ef);
    chk(ready == !ef[0], "R10 ready outcome", ready, !ef);
    chk(fails == exp_fails, "R7 failed attempts", fails, exp_fails);
    chk(dl_err == 0, "R3 R4 deadline respected", dl_err, 0);
    chk(cfg_pulses == 1, "R2 one clock write", cfg_pulses, 1);
    chk(int'(clk_rate) == rate, "R2 clock rate value", clk_rate, rate);
    chk(order_err == 0, "R2 control order", order_err, 0);
    if (fn > 0) chk(min_pd >= PD, "R6 power-down pulse ticks", min_pd, PD);
    if (!ef) begin
      chk(int'(mode_onehot) == exp_oh, "R9 mode decode", mode_onehot, exp_oh);
      chk(cal_ticks >= CAL && cal_ticks <= CAL + 4, "R5 calibration ticks", cal_ticks, CAL);
    end else begin
      chk(power_down && !off_hook && mode_onehot == 0, "R7 fault safe state",
          {power_down, off_hook, mode_onehot}, 8);
    end
    mon_en = 0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    if (ef) begin
      repeat (20) @(negedge clk);
      chk(fault == 1'b1, "R8 fault held with start low", fault, 1);
    end else begin
      chk(power_down && !off_hook && !ready && mode_onehot == 0, "R11 start drop",
          {power_down, off_hook, ready, mode_onehot}, 32);
    end
  endtask

  initial begin
    bit ok;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(power_down == 1'b1, "R1 power_down in reset", power_down, 1);
    chk({clk_cfg_wr, off_hook, ready, fault} == 4'b0, "R1 controls low in reset",
        {clk_cfg_wr, off_hook, ready, fault}, 0);
    chk(mode_onehot == 0, "R1 mode clear in reset", mode_onehot, 0);
    @(negedge clk) rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(power_down && !off_hook && !clk_cfg_wr, "R1 idle after reset",
        {power_down, off_hook, clk_cfg_wr}, 4);

    for (int i = 0; i < NV; i++) run_entry(i);

    // R10: ready tracks link_valid in the run state
    @(negedge clk);
    cur_fail_n = 0; cur_kind = 0; cur_delay = 1; tdiv = 1; test_mode = 2'd1;
    start = 1'b1;
    wait_done(ok);
    chk(ready == 1'b1, "R10 ready after bring-up", ready, 1);
    force_low = 1;
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R10 ready drops with link", ready, 0);
    chk(off_hook == 1'b1, "R10 off_hook kept", off_hook, 1);
    force_low = 0;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R10 ready returns with link", ready, 1);
    start = 1'b0;
    repeat (3) @(negedge clk);

    // R11: start dropped during calibration
    start = 1'b1;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (off_hook) break;
    end
    repeat (5) @(negedge clk);
    chk(off_hook && !ready, "R5 calibrating", {off_hook, ready}, 2);
    start = 1'b0;
    @(negedge clk);
    chk(power_down && !off_hook, "R11 drop during calibration",
        {power_down, off_hook}, 2);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule